// File: doc/BRIEF.md
# XTS Tweak Sequence Generator

This block produces the run of 128-bit tweaks that a block-cipher storage mode needs, one tweak per data block, starting from a tweak that has already been encrypted elsewhere. Each successor is the previous tweak times x in GF(2^128), reduced by x^128 + x^7 + x^2 + x + 1. The cipher core and the encryption of the starting tweak sit outside this block.

The generator holds a window of up to four lanes. Lane k holds the tweak for the k-th block of the current group, so the lanes are consecutive powers of x applied to the group's first tweak. A group step moves the whole window forward by x^N in one cycle, where N is the group size picked at load time. A single step moves it forward by x only. The single step is meant for a partial tail, where fewer than N blocks remain. Lane 0 is always the first unused tweak, and it is brought out on its own port. A transfer can therefore stop after any whole block and later resume by loading that value again.

Top module: `xts_tweak_gen`

## Requirements
- R1: A synchronous active-high `rst` clears every lane and `next_tweak` to zero and drives `adv_ready` low.
- R2: `load_valid` captures `load_tweak` as T and picks the group size N from `lane_sel`: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4, and 2'b11 falls back to 1. N is also capped at the LANES parameter. After the load, lane k (bits [128k+127:128k] of `lanes_out`) holds T·x^k for k < N, and every lane at or above N holds zero.
- R3: Multiplying by x is a left shift of the whole 128-bit value. Bit 63 carries into bit 64. A 1 shifted out of bit 127 XORs 0x87 into the low bits.
- R4: A group step (`adv_valid` and `adv_ready` high, `adv_single` low) multiplies every lane by x^N in one cycle.
- R5: A single step (`adv_valid` and `adv_ready` high, `adv_single` high) multiplies every lane by x. Lane 0 then holds the tweak for the next block of a tail.
- R6: `adv_ready` stays low until the first load. An advance request made before any load has no effect: the outputs stay zero.
- R7: A load wins over an advance presented in the same cycle. `adv_ready` is low while `load_valid` is high.
- R8: `next_tweak` always equals lane 0, which is the first unused tweak. Loading it back with N = 1 continues the same sequence.
- R9: In a cycle with no load and no accepted advance, all lanes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Load a new starting tweak |
| load_tweak | input | 128 | Starting tweak T (already encrypted) |
| lane_sel | input | 2 | Group size code, sampled at load |
| adv_valid | input | 1 | Advance request |
| adv_single | input | 1 | 1: advance by x; 0: advance by x^N |
| adv_ready | output | 1 | Advance is accepted this cycle |
| lanes_out | output | LANES*128 | Lane k at bits [128k+127:128k] |
| next_tweak | output | 128 | First unused tweak (lane 0) |

## Verification
A wrong lane register shows up at the ports on the edge right after the load or step that wrote it. The bad value stays visible, and every later step multiplies it again, so the error spreads through all later outputs. A wrong fold of the bits shifted out of the top only shows when the high bits of a tweak are set. For that reason the starting tweaks include values with bit 127 or bit 63 set, alongside many random values compared against a plain shift-by-one reference model. A wrong group size shows as the next group repeating or skipping tweaks. The bench therefore checks each lane after a group step against the lane indices that follow on without a gap.

// File: rtl/xts_tweak_pkg.sv
package xts_tweak_pkg;

    localparam int TW        = 128;
    localparam int HW        = TW / 2;
    localparam int MAX_LANES = 4;
    localparam logic [7:0] RED_POLY = 8'h87;

    typedef logic [TW-1:0] tweak_t;

    typedef enum logic [1:0] {
        GRP_1   = 2'b00,
        GRP_2   = 2'b01,
        GRP_4   = 2'b10,
        GRP_RSV = 2'b11
    } grp_e;

    typedef struct packed {
        logic [HW-1:0] hi;
        logic [HW-1:0] lo;
    } tweak_halves_t;

    function automatic int grp_lanes(grp_e g);
        case (g)
            GRP_2:   return 2;
            GRP_4:   return 4;
            default: return 1;
        endcase
    endfunction

    // Clip a requested group size to what the instance has lanes for.
    function automatic grp_e fit_grp(grp_e g, int lanes);
        grp_e r;
        r = g;
        if (g == GRP_RSV) r = GRP_1;
        if (r == GRP_4 && lanes < 4) r = (lanes >= 2) ? GRP_2 : GRP_1;
        if (r == GRP_2 && lanes < 2) r = GRP_1;
        return r;
    endfunction

    // Multiply by x^s (s small): shift both halves, move the low half's top
    // bits into the high half, and fold the high half's top bits back
    // through the reduction polynomial with a carry-less product.
    function automatic tweak_t mul_xpow(tweak_t t, int s);
        tweak_halves_t h;
        tweak_halves_t r;
        logic [HW-1:0] top_hi;
        logic [HW-1:0] top_lo;
        logic [HW-1:0] fold;
        h      = t;
        top_hi = h.hi >> (HW - s);
        top_lo = h.lo >> (HW - s);
        fold   = '0;
        for (int b = 0; b < 8; b++) begin
            if (RED_POLY[b]) fold = fold ^ (top_hi << b);
        end
        r.hi = (h.hi << s) | top_lo;
        r.lo = (h.lo << s) ^ fold;
        return r;
    endfunction

endpackage

// File: rtl/xts_lane_seed.sv
module xts_lane_seed
    import xts_tweak_pkg::*;
#(
    parameter int LANES = MAX_LANES
) (
    input  tweak_t               base,
    input  grp_e                 grp,
    output tweak_t [LANES-1:0]   seeds
);
    tweak_t [LANES-1:0] chain;
    int                 n_act;

    assign n_act = grp_lanes(grp);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_seed
            if (k == 0) begin : g_first
                assign chain[k] = base;
            end else begin : g_next
                assign chain[k] = mul_xpow(chain[k-1], 1);
            end
            assign seeds[k] = (k < n_act) ? chain[k] : '0;
        end
    endgenerate

endmodule

// File: rtl/xts_lane_step.sv
module xts_lane_step
    import xts_tweak_pkg::*;
(
    input  tweak_t cur,
    input  grp_e   grp,
    input  logic   single,
    output tweak_t nxt
);
    tweak_t by1, by2, by4;

    assign by1 = mul_xpow(cur, 1);
    assign by2 = mul_xpow(cur, 2);
    assign by4 = mul_xpow(cur, 4);

    always_comb begin
        if (single) begin
            nxt = by1;
        end else begin
            case (grp)
                GRP_2:   nxt = by2;
                GRP_4:   nxt = by4;
                default: nxt = by1;
            endcase
        end
    end

endmodule

// File: rtl/xts_tweak_gen.sv
module xts_tweak_gen
    import xts_tweak_pkg::*;
#(
    parameter int LANES = MAX_LANES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_valid,
    input  logic [TW-1:0]       load_tweak,
    input  logic [1:0]          lane_sel,
    input  logic                adv_valid,
    input  logic                adv_single,
    output logic                adv_ready,
    output logic [LANES*TW-1:0] lanes_out,
    output logic [TW-1:0]       next_tweak
);
    tweak_t             lane_q [LANES];
    tweak_t [LANES-1:0] seed_w;
    tweak_t             step_w [LANES];
    logic               loaded_q;
    grp_e               grp_q;
    grp_e               grp_in;
    logic               fire;

    assign grp_in    = fit_grp(grp_e'(lane_sel), LANES);
    assign adv_ready = loaded_q && !load_valid;
    assign fire      = adv_valid && adv_ready;

    xts_lane_seed #(.LANES(LANES)) u_seed (
        .base  (load_tweak),
        .grp   (grp_in),
        .seeds (seed_w)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            xts_lane_step u_step (
                .cur    (lane_q[k]),
                .grp    (grp_q),
                .single (adv_single),
                .nxt    (step_w[k])
            );
            assign lanes_out[k*TW +: TW] = lane_q[k];
        end
    endgenerate

    assign next_tweak = lane_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded_q <= 1'b0;
            grp_q    <= GRP_1;
            for (int k = 0; k < LANES; k++) lane_q[k] <= '0;
        end else if (load_valid) begin
            loaded_q <= 1'b1;
            grp_q    <= grp_in;
            for (int k = 0; k < LANES; k++) lane_q[k] <= seed_w[k];
        end else if (fire) begin
            for (int k = 0; k < LANES; k++) lane_q[k] <= step_w[k];
        end
    end

endmodule

// File: rtl/xts_tweak_gen_chk.sv
module xts_tweak_gen_chk
    import xts_tweak_pkg::*;
#(
    parameter int LANES = MAX_LANES
) (
    input logic                clk,
    input logic                rst,
    input logic                load_valid,
    input logic [TW-1:0]       load_tweak,
    input logic                adv_valid,
    input logic                adv_single,
    input logic                adv_ready,
    input logic [LANES*TW-1:0] lanes_out,
    input logic [TW-1:0]       next_tweak,
    input logic                loaded_q,
    input grp_e                grp_q
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lanes_out == '0 && !adv_ready));

    // R6
    idle_until_load_chk: assert property (@(posedge clk) disable iff (rst)
        !loaded_q |-> (lanes_out == '0 && !adv_ready));

    // R2
    load_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        load_valid |=> next_tweak == $past(load_tweak));

    // R4
    group_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_valid && adv_ready && !adv_single) |=>
            next_tweak == mul_xpow($past(next_tweak), grp_lanes(grp_q)));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_valid && adv_ready && adv_single) |=>
            next_tweak == mul_xpow($past(next_tweak), 1));

    // R7
    load_priority_chk: assert property (@(posedge clk) disable iff (rst)
        load_valid |-> !adv_ready);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_valid && !(adv_valid && adv_ready)) |=> $stable(lanes_out));

endmodule

bind xts_tweak_gen xts_tweak_gen_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_valid (load_valid),
    .load_tweak (load_tweak),
    .adv_valid  (adv_valid),
    .adv_single (adv_single),
    .adv_ready  (adv_ready),
    .lanes_out  (lanes_out),
    .next_tweak (next_tweak),
    .loaded_q   (loaded_q),
    .grp_q      (grp_q)
);

// File: tb/sim_xts_tweak_gen.sv
module sim_xts_tweak_gen;
    localparam int L = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           load_valid = 1'b0;
    logic [127:0]   load_tweak = '0;
    logic [1:0]     lane_sel = 2'b00;
    logic           adv_valid = 1'b0;
    logic           adv_single = 1'b0;
    logic           adv_ready;
    logic [L*128-1:0] lanes_out;
    logic [127:0]   next_tweak;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    xts_tweak_gen #(.LANES(L)) u0 (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_tweak(load_tweak),
        .lane_sel(lane_sel), .adv_valid(adv_valid), .adv_single(adv_single),
        .adv_ready(adv_ready), .lanes_out(lanes_out), .next_tweak(next_tweak)
    );

    // Reference: whole-value shift by one, fold 0x87 on carry out of bit 127.
    function automatic logic [127:0] ref_x(logic [127:0] t);
        return {t[126:0], 1'b0} ^ (t[127] ? 128'h87 : 128'h0);
    endfunction

    function automatic logic [127:0] ref_xn(logic [127:0] t, int n);
        logic [127:0] r;
        r = t;
        for (int i = 0; i < n; i++) r = ref_x(r);
        return r;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(logic [127:0] t, logic [1:0] sel, logic with_adv);
        load_tweak = t; lane_sel = sel; load_valid = 1'b1;
        adv_valid = with_adv; adv_single = 1'b0;
        @(negedge clk);
        load_valid = 1'b0; adv_valid = 1'b0;
    endtask

    task automatic do_adv(logic single);
        adv_valid = 1'b1; adv_single = single;
        @(negedge clk);
        adv_valid = 1'b0; adv_single = 1'b0;
    endtask

    function automatic logic [127:0] lane(int k);
        return lanes_out[k*128 +: 128];
    endfunction

    localparam int NV = 5;
    localparam logic [127:0] VEC_IN [NV] = '{
        128'h1,
        128'h0000_0000_0000_0000_8000_0000_0000_0000,
        128'h8000_0000_0000_0000_0000_0000_0000_0000,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h8000_0000_0000_0000_8000_0000_0000_0000
    };
    localparam logic [127:0] VEC_EXP [NV] = '{
        128'h2,
        128'h0000_0000_0000_0001_0000_0000_0000_0000,
        128'h0000_0000_0000_0000_0000_0000_0000_0087,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FF79,
        128'h0000_0000_0000_0001_0000_0000_0000_0087
    };

    initial begin
        logic [127:0] t, nt, snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 next_tweak after reset", next_tweak, 128'h0);
        check("R1 adv_ready after reset", {127'b0, adv_ready}, 128'h0);
        // R6 advance before any load is ignored
        do_adv(1'b0);
        check("R6 next_tweak unchanged", next_tweak, 128'h0);
        check("R6 adv_ready low", {127'b0, adv_ready}, 128'h0);

        // R3 fixed vectors: one single step per entry
        for (int v = 0; v < NV; v++) begin
            do_load(VEC_IN[v], 2'b00, 1'b0);
            check("R2 lane1 unused", lane(1), 128'h0);
            do_adv(1'b1);
            check("R3 mul by x", next_tweak, VEC_EXP[v]);
        end

        // R2/R4/R5 random tweaks, each group size
        for (int i = 0; i < 64; i++) begin
            t = {$urandom(), $urandom(), $urandom(), $urandom()};
            for (int g = 0; g < 3; g++) begin
                int n;
                n = (g == 0) ? 1 : (g == 1) ? 2 : 4;
                do_load(t, 2'(g), 1'b0);
                for (int k = 0; k < L; k++)
                    check("R2 seed lane", lane(k), (k < n) ? ref_xn(t, k) : 128'h0);
                do_adv(1'b0);
                for (int k = 0; k < n; k++)
                    check("R4 group step lane", lane(k), ref_xn(t, n + k));
                do_adv(1'b1);
                for (int k = 0; k < n; k++)
                    check("R5 single step lane", lane(k), ref_xn(t, n + k + 1));
            end
        end

        // R7 load wins over same-cycle advance
        t = {$urandom(), $urandom(), $urandom(), $urandom()};
        do_load(128'h1234, 2'b00, 1'b0);
        do_load(t, 2'b01, 1'b1);
        check("R7 load priority lane0", lane(0), t);
        check("R7 load priority lane1", lane(1), ref_x(t));

        // R8 continuation through next_tweak
        t = 128'h8000_0000_0000_0001_8000_0000_0000_0003;
        do_load(t, 2'b10, 1'b0);
        do_adv(1'b0);
        do_adv(1'b0);
        nt = next_tweak;
        check("R8 next_tweak after two groups", nt, ref_xn(t, 8));
        do_load(nt, 2'b00, 1'b0);
        do_adv(1'b1);
        check("R8 resumed sequence", next_tweak, ref_xn(t, 9));

        // R9 hold with no request
        snap = next_tweak;
        repeat (3) @(negedge clk);
        check("R9 hold", next_tweak, snap);

        // R2 reserved code maps to one lane
        t = 128'hC000_0000_0000_0000_0000_0000_0000_0001;
        do_load(t, 2'b11, 1'b0);
        check("R2 code 11 lane1 zero", lane(1), 128'h0);
        do_adv(1'b0);
        check("R2 code 11 steps by x", next_tweak, ref_x(t));

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 cleared mid-run", next_tweak, 128'h0);
        check("R1 ready low mid-run", {127'b0, adv_ready}, 128'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule